// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two binary floating-point operands in a fixed-latency pipeline. The operation is chosen when the block is built. One operand pair can enter on every clock cycle. Each result comes out a fixed number of cycles later, together with a valid strobe and six status flags: overflow, underflow, quiet NaN, signalling NaN, positive infinity and negative infinity. By default the exponent and fraction widths give IEEE-754 single precision. Both widths are parameters.

The datapath works in four steps. It orders the two operands by magnitude and shifts the smaller significand right into guard, round and sticky positions. It then adds or subtracts the significands and renormalises the sum. Finally it rounds to nearest, with ties going to even. Subtraction uses the same path, with the sign of the second operand flipped. Special operands bypass the arithmetic through a fixed decision table.

Operands with a zero exponent field are treated as zero. A finite result that falls outside the normal range is not saturated. It is replaced by a fixed positive NaN code, and the flag for its cause is set.

Top module: `fp_addsub_pipe`

## Requirements
- R1: A result appears on `res` with `res_valid` high exactly LATENCY (default 16) cycles after `op_valid` was sampled high. Operands may be presented on every cycle, and `res_valid` never rises without a matching input.
- R2: Finite results are rounded to nearest, with ties to even. For example, 0x4E989680 + 0x4F191B40 = 0x4F656680, 0x3F800000 + 0x33800000 = 0x3F800000 and 0x3F800001 + 0x33800000 = 0x3F800002.
- R3: If either operand is a NaN (exponent all ones, fraction nonzero), whether quiet or signalling, the result is the positive quiet NaN 0x7FC00000. Only the quiet-NaN flag is set.
- R4: A sum that is exactly zero, including zero plus zero of any signs and x − x, is +0 (0x00000000) with all flags clear.
- R5: Infinities that cancel give 0x7FC00000 with only the quiet-NaN flag set. This covers +inf + −inf in add mode and +inf − +inf in subtract mode.
- R6: An infinite operand that does not cancel passes through with its effective sign. The positive-infinity flag is set alone for 0x7F800000 and the negative-infinity flag alone for 0xFF800000.
- R7: A finite result whose rounded exponent reaches the all-ones code becomes 0x7FA00000 with only the overflow and signalling-NaN flags set. No unflagged result carries an all-ones exponent.
- R8: A nonzero finite result whose rounded exponent is at or below zero becomes 0x7FA00000 with only the underflow and signalling-NaN flags set.
- R9: With SUBTRACT=1 the block computes opa − opb by flipping the sign of opb. For example, 0xAC85465F − 0x2F516779 = 0xAF5591AC.
- R10: An operand with a zero exponent field and a nonzero fraction is treated as zero. For example, 0x00000001 + 0x3F800000 = 0x3F800000.
- R11: While `rst_n` is low, `res_valid` is low and the pipeline holds no operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operand pair valid this cycle |
| opa | input | 1+EXP_W+MAN_W | First operand |
| opb | input | 1+EXP_W+MAN_W | Second operand |
| res_valid | output | 1 | Result valid |
| res | output | 1+EXP_W+MAN_W | Result word |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_qnan | output | 1 | Quiet-NaN result |
| flag_snan | output | 1 | Signalling-NaN pattern (overflow or underflow) |
| flag_pinf | output | 1 | Positive infinity result |
| flag_ninf | output | 1 | Negative infinity result |

## Verification
The bench builds four instances. Two use an 8-bit format (EXP_W=4, MAN_W=3), one in each operation mode. Because that format is so small, every one of the 65,536 operand pairs can be checked in both modes against an exact integer model of the sum. The sweep therefore reaches every alignment distance, every cancellation depth, every rounding tie, and every overflow, underflow and special-operand combination. The other two instances use the default single-precision widths. They receive directed vectors, including ties at the last fraction bit and carry-out of rounding into overflow.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;

    // Status flags carried alongside every result word.
    typedef struct packed {
        logic ovf;
        logic unf;
        logic qnan;
        logic snan;
        logic pinf;
        logic ninf;
    } fpas_flags_t;

    localparam int FLAG_W = 6;

endpackage

// File: rtl/fp_addsub_align.sv
// Stage 1: classify operands, resolve specials, order by magnitude and
// align the smaller significand with guard/round/sticky bits.
module fp_addsub_align
    import fp_addsub_pkg::*;
#(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 23,
    parameter bit SUBTRACT = 1'b0,
    localparam int WORD    = 1 + EXP_W + MAN_W,
    localparam int SIG     = MAN_W + 1,
    localparam int AW      = SIG + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WORD-1:0]  opa,
    input  logic [WORD-1:0]  opb,
    output logic             s1_valid,
    output logic             s1_spec,
    output logic [WORD-1:0]  s1_spec_word,
    output fpas_flags_t      s1_spec_flags,
    output logic             s1_sign,
    output logic             s1_sub,
    output logic [EXP_W-1:0] s1_exp,
    output logic [AW-1:0]    s1_x,
    output logic [AW-1:0]    s1_y
);

    localparam int EXW = 2 * SIG + 3;
    localparam logic [WORD-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic             valid;
        logic             spec;
        logic [WORD-1:0]  spec_word;
        fpas_flags_t      spec_flags;
        logic             sign;
        logic             sub;
        logic [EXP_W-1:0] exp_l;
        logic [AW-1:0]    x;
        logic [AW-1:0]    y;
    } stage_t;

    stage_t st_d, st_q;

    logic             a_s, b_s;
    logic [EXP_W-1:0] a_e, b_e;
    logic [MAN_W-1:0] a_m, b_m;
    logic             a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
    logic [EXP_W+MAN_W-1:0] key_a, key_b;
    logic             a_big;
    logic [SIG-1:0]   sig_a, sig_b, sig_l, sig_s;
    logic [EXP_W-1:0] ex_a, ex_b, ex_l, ex_s, diff;
    int               sh;
    logic [EXW-1:0]   ext, shf;
    logic [AW-1:0]    y_al;

    assign a_s = opa[WORD-1];
    assign b_s = opb[WORD-1] ^ SUBTRACT;
    assign a_e = opa[WORD-2 -: EXP_W];
    assign b_e = opb[WORD-2 -: EXP_W];
    assign a_m = opa[MAN_W-1:0];
    assign b_m = opb[MAN_W-1:0];

    assign a_zero = (a_e == '0);
    assign b_zero = (b_e == '0);
    assign a_inf  = (a_e == '1) && (a_m == '0);
    assign b_inf  = (b_e == '1) && (b_m == '0);
    assign a_nan  = (a_e == '1) && (a_m != '0);
    assign b_nan  = (b_e == '1) && (b_m != '0);

    assign key_a = a_zero ? '0 : opa[WORD-2:0];
    assign key_b = b_zero ? '0 : opb[WORD-2:0];
    assign a_big = (key_a >= key_b);

    assign sig_a = a_zero ? '0 : {1'b1, a_m};
    assign sig_b = b_zero ? '0 : {1'b1, b_m};
    assign ex_a  = a_zero ? '0 : a_e;
    assign ex_b  = b_zero ? '0 : b_e;

    assign sig_l = a_big ? sig_a : sig_b;
    assign sig_s = a_big ? sig_b : sig_a;
    assign ex_l  = a_big ? ex_a : ex_b;
    assign ex_s  = a_big ? ex_b : ex_a;
    assign diff  = ex_l - ex_s;
    assign sh    = (int'(diff) >= AW) ? AW : int'(diff);

    assign ext  = {sig_s, {(SIG+3){1'b0}}};
    assign shf  = ext >> sh;
    assign y_al = shf[EXW-1 -: AW] | {{(AW-1){1'b0}}, |shf[SIG-1:0]};

    always_comb begin
        st_d        = '0;
        st_d.valid  = in_valid;
        st_d.sign   = a_big ? a_s : b_s;
        st_d.sub    = a_s ^ b_s;
        st_d.exp_l  = ex_l;
        st_d.x      = {sig_l, 3'b000};
        st_d.y      = y_al;
        if (a_nan || b_nan) begin
            st_d.spec            = 1'b1;
            st_d.spec_word       = QNAN_W;
            st_d.spec_flags.qnan = 1'b1;
        end else if (a_inf && b_inf && (a_s != b_s)) begin
            st_d.spec            = 1'b1;
            st_d.spec_word       = QNAN_W;
            st_d.spec_flags.qnan = 1'b1;
        end else if (a_inf || b_inf) begin
            st_d.spec            = 1'b1;
            st_d.spec_word       = {a_inf ? a_s : b_s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            st_d.spec_flags.pinf = !(a_inf ? a_s : b_s);
            st_d.spec_flags.ninf =  (a_inf ? a_s : b_s);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid      = st_q.valid;
    assign s1_spec       = st_q.spec;
    assign s1_spec_word  = st_q.spec_word;
    assign s1_spec_flags = st_q.spec_flags;
    assign s1_sign       = st_q.sign;
    assign s1_sub        = st_q.sub;
    assign s1_exp        = st_q.exp_l;
    assign s1_x          = st_q.x;
    assign s1_y          = st_q.y;

    // A zero larger operand implies a zero aligned smaller operand.
    AST_ZERO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !st_q.spec && !st_q.x[AW-1]) |-> (st_q.y == '0)); // R4

endmodule

// File: rtl/fp_addsub_norm.sv
// Stage 2: significand add/subtract, renormalise, round to nearest even,
// range check and final result selection.
module fp_addsub_norm
    import fp_addsub_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD = 1 + EXP_W + MAN_W,
    localparam int SIG  = MAN_W + 1,
    localparam int AW   = SIG + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_spec,
    input  logic [WORD-1:0]  in_spec_word,
    input  fpas_flags_t      in_spec_flags,
    input  logic             in_sign,
    input  logic             in_sub,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [AW-1:0]    in_x,
    input  logic [AW-1:0]    in_y,
    output logic             out_valid,
    output logic [WORD-1:0]  out_word,
    output fpas_flags_t      out_flags
);

    localparam int EMAX = (1 << EXP_W) - 1;
    localparam logic [WORD-1:0] SNAN_W = {1'b0, {EXP_W{1'b1}}, 2'b01, {(MAN_W-2){1'b0}}};

    typedef struct packed {
        logic            valid;
        logic [WORD-1:0] word;
        fpas_flags_t     flags;
    } stage_t;

    stage_t st_d, st_q;

    logic [AW:0]      z, nz;
    int               lead, lz, e_res;
    logic [SIG-1:0]   mant;
    logic             guard, sticky, inc;
    logic [SIG:0]     rnd;
    logic [MAN_W-1:0] frac;

    assign z = in_sub ? ({1'b0, in_x} - {1'b0, in_y}) : ({1'b0, in_x} + {1'b0, in_y});

    always_comb begin
        lead = 0;
        for (int i = 0; i <= AW; i++) begin
            if (z[i]) lead = i;
        end
    end

    assign lz     = AW - lead;
    assign nz     = z << lz;
    assign mant   = nz[AW -: SIG];
    assign guard  = nz[AW-SIG];
    assign sticky = |nz[AW-SIG-1:0];
    assign inc    = guard & (sticky | mant[0]);
    assign rnd    = {1'b0, mant} + {{SIG{1'b0}}, inc};
    assign e_res  = int'(in_exp) + 1 - lz + (rnd[SIG] ? 1 : 0);
    assign frac   = rnd[SIG] ? '0 : rnd[MAN_W-1:0];

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid;
        if (in_spec) begin
            st_d.word  = in_spec_word;
            st_d.flags = in_spec_flags;
        end else if (z == '0) begin
            st_d.word = '0;
        end else if (e_res >= EMAX) begin
            st_d.word       = SNAN_W;
            st_d.flags.ovf  = 1'b1;
            st_d.flags.snan = 1'b1;
        end else if (e_res <= 0) begin
            st_d.word       = SNAN_W;
            st_d.flags.unf  = 1'b1;
            st_d.flags.snan = 1'b1;
        end else begin
            st_d.word = {in_sign, (EXP_W)'(e_res), frac};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
    assign out_flags = st_q.flags;

    AST_FINITE_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.flags == '0) |-> (st_q.word[WORD-2 -: EXP_W] != '1)); // R7

endmodule

// File: rtl/fp_addsub_delay.sv
// Balancing delay line that pads the compute stages to the fixed latency.
module fp_addsub_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_pipe
            logic [W:0] pipe_d [DEPTH];
            logic [W:0] pipe_q [DEPTH];

            always_comb begin
                pipe_d[0] = {in_valid, in_data};
                for (int i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
                end else begin
                    for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
                end
            end

            assign out_valid = pipe_q[DEPTH-1][W];
            assign out_data  = pipe_q[DEPTH-1][W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fp_addsub_pipe.sv
module fp_addsub_pipe
    import fp_addsub_pkg::*;
#(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 23,
    parameter bit SUBTRACT = 1'b0,
    parameter int LATENCY  = 16,
    localparam int WORD    = 1 + EXP_W + MAN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [WORD-1:0] opa,
    input  logic [WORD-1:0] opb,
    output logic            res_valid,
    output logic [WORD-1:0] res,
    output logic            flag_ovf,
    output logic            flag_unf,
    output logic            flag_qnan,
    output logic            flag_snan,
    output logic            flag_pinf,
    output logic            flag_ninf
);

    localparam int SIG   = MAN_W + 1;
    localparam int AW    = SIG + 3;
    localparam int PAD   = LATENCY - 2;
    localparam int DW    = WORD + FLAG_W;
    localparam int CW    = $clog2(LATENCY + 1) + 1;
    localparam logic [WORD-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [WORD-1:0] SNAN_W = {1'b0, {EXP_W{1'b1}}, 2'b01, {(MAN_W-2){1'b0}}};
    localparam logic [WORD-1:0] PINF_W = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};

    logic             s1_valid, s1_spec, s1_sign, s1_sub;
    logic [WORD-1:0]  s1_spec_word;
    fpas_flags_t      s1_spec_flags;
    logic [EXP_W-1:0] s1_exp;
    logic [AW-1:0]    s1_x, s1_y;

    logic             s2_valid;
    logic [WORD-1:0]  s2_word;
    fpas_flags_t      s2_flags;

    logic [DW-1:0]    out_data;
    fpas_flags_t      out_flags;

    fp_addsub_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SUBTRACT(SUBTRACT)) u_align (
        .clk(clk), .rst_n(rst_n), .in_valid(op_valid), .opa(opa), .opb(opb),
        .s1_valid(s1_valid), .s1_spec(s1_spec), .s1_spec_word(s1_spec_word),
        .s1_spec_flags(s1_spec_flags), .s1_sign(s1_sign), .s1_sub(s1_sub),
        .s1_exp(s1_exp), .s1_x(s1_x), .s1_y(s1_y)
    );

    fp_addsub_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_spec(s1_spec),
        .in_spec_word(s1_spec_word), .in_spec_flags(s1_spec_flags),
        .in_sign(s1_sign), .in_sub(s1_sub), .in_exp(s1_exp), .in_x(s1_x), .in_y(s1_y),
        .out_valid(s2_valid), .out_word(s2_word), .out_flags(s2_flags)
    );

    fp_addsub_delay #(.W(DW), .DEPTH(PAD)) u_delay (
        .clk(clk), .rst_n(rst_n), .in_valid(s2_valid), .in_data({s2_word, s2_flags}),
        .out_valid(res_valid), .out_data(out_data)
    );

    assign res       = out_data[DW-1 -: WORD];
    assign out_flags = out_data[FLAG_W-1:0];
    assign flag_ovf  = out_flags.ovf;
    assign flag_unf  = out_flags.unf;
    assign flag_qnan = out_flags.qnan;
    assign flag_snan = out_flags.snan;
    assign flag_pinf = out_flags.pinf;
    assign flag_ninf = out_flags.ninf;

    // In-flight operation count, used only by the checks below.
    logic [CW-1:0] cnt_d, cnt_q;
    always_comb cnt_d = cnt_q + CW'(op_valid) - CW'(res_valid);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= LATENCY); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (cnt_q != '0)); // R1
    AST_QNAN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flag_qnan) |-> (res == QNAN_W && !flag_snan)); // R3
    AST_OVF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flag_ovf) |-> (res == SNAN_W && flag_snan && !flag_unf)); // R7
    AST_UNF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flag_unf) |-> (res == SNAN_W && flag_snan && !flag_ovf)); // R8
    AST_PINF_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flag_pinf) |-> (res == PINF_W)); // R6
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0({flag_qnan, flag_snan, flag_pinf, flag_ninf})); // R6

endmodule

// File: tb/fp_addsub_pipe_tb.sv
module fp_addsub_pipe_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    int   checks = 0;
    int   errors = 0;
    longint cyc = 0;
    always @(posedge clk) cyc++;

    typedef struct { logic [31:0] word; logic [5:0] flags; longint t; string tag; } exp32_t;
    typedef struct { logic [7:0]  word; logic [5:0] flags; longint t; string tag; } exp8_t;

    exp32_t q_add[$];
    exp32_t q_sub[$];
    exp8_t  q_sadd[$];
    exp8_t  q_ssub[$];

    logic [31:0] a32 = '0, b32 = '0;
    logic        v_add = 1'b0, v_sub = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        v8 = 1'b0;

    logic [31:0] r_add, r_sub;
    logic [7:0]  r_sadd, r_ssub;
    logic        rv_add, rv_sub, rv_sadd, rv_ssub;
    logic [5:0]  f_add, f_sub, f_sadd, f_ssub;

    fp_addsub_pipe #(.SUBTRACT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(v_add), .opa(a32), .opb(b32),
        .res_valid(rv_add), .res(r_add), .flag_ovf(f_add[5]), .flag_unf(f_add[4]),
        .flag_qnan(f_add[3]), .flag_snan(f_add[2]), .flag_pinf(f_add[1]), .flag_ninf(f_add[0]));

    fp_addsub_pipe #(.SUBTRACT(1'b1)) u_dut_sub (
        .clk(clk), .rst_n(rst_n), .op_valid(v_sub), .opa(a32), .opb(b32),
        .res_valid(rv_sub), .res(r_sub), .flag_ovf(f_sub[5]), .flag_unf(f_sub[4]),
        .flag_qnan(f_sub[3]), .flag_snan(f_sub[2]), .flag_pinf(f_sub[1]), .flag_ninf(f_sub[0]));

    fp_addsub_pipe #(.EXP_W(4), .MAN_W(3), .SUBTRACT(1'b0)) u_dut_small_add (
        .clk(clk), .rst_n(rst_n), .op_valid(v8), .opa(a8), .opb(b8),
        .res_valid(rv_sadd), .res(r_sadd), .flag_ovf(f_sadd[5]), .flag_unf(f_sadd[4]),
        .flag_qnan(f_sadd[3]), .flag_snan(f_sadd[2]), .flag_pinf(f_sadd[1]), .flag_ninf(f_sadd[0]));

    fp_addsub_pipe #(.EXP_W(4), .MAN_W(3), .SUBTRACT(1'b1)) u_dut_small_sub (
        .clk(clk), .rst_n(rst_n), .op_valid(v8), .opa(a8), .opb(b8),
        .res_valid(rv_ssub), .res(r_ssub), .flag_ovf(f_ssub[5]), .flag_unf(f_ssub[4]),
        .flag_qnan(f_ssub[3]), .flag_snan(f_ssub[2]), .flag_pinf(f_ssub[1]), .flag_ninf(f_ssub[0]));

    // Exact reference for the 8-bit format (4 exponent bits, 3 fraction bits, bias 7).
    // Flag vector order: {ovf, unf, qnan, snan, pinf, ninf}.
    function automatic exp8_t ref8(bit sub, logic [7:0] a, logic [7:0] b);
        exp8_t r;
        int ea, eb, ma, mb, va, vb, sum, mag, t, sh, q, rem, half, be;
        bit sa, sb, an, bn, ai, bi;
        sa = a[7]; ea = int'(a[6:3]); ma = int'(a[2:0]);
        sb = b[7] ^ sub; eb = int'(b[6:3]); mb = int'(b[2:0]);
        an = (ea == 15) && (ma != 0); bn = (eb == 15) && (mb != 0);
        ai = (ea == 15) && (ma == 0); bi = (eb == 15) && (mb == 0);
        r.t = 0; r.flags = 6'b000000; r.word = 8'h00;
        r.tag = ((ea == 0 && ma != 0) || (eb == 0 && mb != 0)) ? "R10" : "R2";
        if (an || bn) begin
            r.word = 8'h7C; r.flags = 6'b001000; r.tag = "R3";
        end else if (ai && bi && (sa != sb)) begin
            r.word = 8'h7C; r.flags = 6'b001000; r.tag = "R5";
        end else if (ai || bi) begin
            r.word = (ai ? sa : sb) ? 8'hF8 : 8'h78;
            r.flags = (ai ? sa : sb) ? 6'b000001 : 6'b000010; r.tag = "R6";
        end else begin
            va = (ea == 0) ? 0 : ((8 + ma) << (ea - 1));
            vb = (eb == 0) ? 0 : ((8 + mb) << (eb - 1));
            sum = (sa ? -va : va) + (sb ? -vb : vb);
            if (sum == 0) begin
                if (r.tag == "R2") r.tag = "R4";
            end else begin
                mag = (sum < 0) ? -sum : sum;
                t = 0;
                for (int i = 0; i < 30; i++) if (((mag >> i) & 1) == 1) t = i;
                if (t > 3) begin
                    sh = t - 3; q = mag >> sh; rem = mag & ((1 << sh) - 1); half = 1 << (sh - 1);
                    if (rem > half || (rem == half && (q % 2) == 1)) q++;
                    if (q == 16) begin q = q >> 1; sh++; end
                    be = sh + 1;
                end else begin
                    q = mag << (3 - t); be = t - 2;
                end
                if (be >= 15) begin
                    r.word = 8'h7A; r.flags = 6'b100100; r.tag = "R7";
                end else if (be <= 0) begin
                    r.word = 8'h7A; r.flags = 6'b010100; r.tag = "R8";
                end else begin
                    r.word = {sum < 0, 4'(be), 3'(q)};
                end
            end
        end
        return r;
    endfunction

    function automatic void cmp(string who, logic [31:0] w, logic [5:0] f,
                                logic [31:0] ew, logic [5:0] ef, longint t, string tag);
        checks++;
        if (w !== ew || f !== ef) begin
            errors++;
            $display("FAIL %s %s: result %h flags %b, expected %h flags %b", tag, who, w, f, ew, ef);
        end
        checks++;
        if (cyc - t != 16) begin
            errors++;
            $display("FAIL R1 %s: latency %0d, expected 16", who, cyc - t);
        end
    endfunction

    function automatic void spurious(string who);
        checks++; errors++;
        $display("FAIL R1 %s: res_valid with no pending input, expected 0", who);
    endfunction

    always @(posedge clk) begin
        exp32_t e32;
        exp8_t  e8;
        #5;
        if (rst_n) begin
            if (rv_add) begin
                if (q_add.size() == 0) spurious("add32");
                else begin e32 = q_add.pop_front(); cmp("add32", r_add, f_add, e32.word, e32.flags, e32.t, e32.tag); end
            end
            if (rv_sub) begin
                if (q_sub.size() == 0) spurious("sub32");
                else begin e32 = q_sub.pop_front(); cmp("sub32", r_sub, f_sub, e32.word, e32.flags, e32.t, e32.tag); end
            end
            if (rv_sadd) begin
                if (q_sadd.size() == 0) spurious("add8");
                else begin e8 = q_sadd.pop_front(); cmp("add8", {24'h0, r_sadd}, f_sadd, {24'h0, e8.word}, e8.flags, e8.t, e8.tag); end
            end
            if (rv_ssub) begin
                if (q_ssub.size() == 0) spurious("sub8");
                else begin e8 = q_ssub.pop_front(); cmp("sub8", {24'h0, r_ssub}, f_ssub, {24'h0, e8.word}, e8.flags, e8.t, e8.tag); end
            end
        end
    end

    task automatic issue32(bit sub, logic [31:0] a, logic [31:0] b,
                           logic [31:0] w, logic [5:0] f, string tag);
        exp32_t e;
        a32 = a; b32 = b; v_add = !sub; v_sub = sub;
        e.word = w; e.flags = f; e.t = cyc; e.tag = tag;
        if (sub) q_sub.push_back(e); else q_add.push_back(e);
        @(negedge clk);
        v_add = 1'b0; v_sub = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: nothing valid under reset
        checks++;
        if (rv_add || rv_sub || rv_sadd || rv_ssub) begin
            errors++;
            $display("FAIL R11: res_valid %b%b%b%b during reset, expected 0000", rv_add, rv_sub, rv_sadd, rv_ssub);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Add mode, single precision
        issue32(0, 32'h4E989680, 32'h4F191B40, 32'h4F656680, 6'b000000, "R2");
        issue32(0, 32'h3F800000, 32'h33800000, 32'h3F800000, 6'b000000, "R2");
        issue32(0, 32'h3F800001, 32'h33800000, 32'h3F800002, 6'b000000, "R2");
        issue32(0, 32'h3F800000, 32'h33800001, 32'h3F800001, 6'b000000, "R2");
        issue32(0, 32'h7FC00000, 32'h3F800000, 32'h7FC00000, 6'b001000, "R3");
        issue32(0, 32'h00000000, 32'h7F800001, 32'h7FC00000, 6'b001000, "R3");
        issue32(0, 32'h00000000, 32'h80000000, 32'h00000000, 6'b000000, "R4");
        issue32(0, 32'h3F800000, 32'hBF800000, 32'h00000000, 6'b000000, "R4");
        issue32(0, 32'h7F800000, 32'hFF800000, 32'h7FC00000, 6'b001000, "R5");
        issue32(0, 32'h7F800000, 32'h3F800000, 32'h7F800000, 6'b000010, "R6");
        issue32(0, 32'hFF800000, 32'h7F7FFFFF, 32'hFF800000, 6'b000001, "R6");
        issue32(0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7FA00000, 6'b100100, "R7");
        issue32(0, 32'h7F7FFFFF, 32'h73000000, 32'h7FA00000, 6'b100100, "R7");
        issue32(0, 32'h00800001, 32'h80800000, 32'h7FA00000, 6'b010100, "R8");
        issue32(0, 32'h00000001, 32'h3F800000, 32'h3F800000, 6'b000000, "R10");
        issue32(0, 32'h00400000, 32'h80000000, 32'h00000000, 6'b000000, "R10");
        // Subtract mode, single precision
        issue32(1, 32'hAC85465F, 32'h2F516779, 32'hAF5591AC, 6'b000000, "R9");
        issue32(1, 32'h40000000, 32'h3F800000, 32'h3F800000, 6'b000000, "R9");
        issue32(1, 32'h3F800000, 32'h40000000, 32'hBF800000, 6'b000000, "R9");
        issue32(1, 32'h7F800000, 32'h7F800000, 32'h7FC00000, 6'b001000, "R5");
        issue32(1, 32'hFF800000, 32'hFF800000, 32'h7FC00000, 6'b001000, "R5");
        issue32(1, 32'h7F800000, 32'hFF800000, 32'h7F800000, 6'b000010, "R6");
        issue32(1, 32'h00000000, 32'h7F800000, 32'hFF800000, 6'b000001, "R6");
        issue32(1, 32'h3F800000, 32'h3F800000, 32'h00000000, 6'b000000, "R4");
        issue32(1, 32'h80000000, 32'h00000000, 32'h00000000, 6'b000000, "R4");
        issue32(1, 32'h00800001, 32'h00800000, 32'h7FA00000, 6'b010100, "R8");
        issue32(1, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'h7FA00000, 6'b100100, "R7");
        issue32(1, 32'h7FA00000, 32'h00000000, 32'h7FC00000, 6'b001000, "R3");

        // Exhaustive 8-bit sweep, one pair per cycle, both modes (R1, R2..R10)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                exp8_t ea, es;
                a8 = 8'(a); b8 = 8'(b); v8 = 1'b1;
                ea = ref8(1'b0, 8'(a), 8'(b)); ea.t = cyc;
                es = ref8(1'b1, 8'(a), 8'(b)); es.t = cyc;
                q_sadd.push_back(ea);
                q_ssub.push_back(es);
                @(negedge clk);
            end
        end
        v8 = 1'b0;

        repeat (30) @(negedge clk);
        // R1: every accepted operation produced exactly one result
        checks++;
        if (q_add.size() + q_sub.size() + q_sadd.size() + q_ssub.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d results missing, expected 0",
                     q_add.size() + q_sub.size() + q_sadd.size() + q_ssub.size());
        end
        summary();
    end

endmodule